// File: doc/BRIEF.md
# Single-Clock 9-Bit FIFO Controller with Read Rewind

This block is a first-in/first-out buffer of 9-bit words. Its depth is set by a parameter and is normally 1024, 2048 or 4096 words. All control strobes are active low and are sampled on the rising clock edge as synchronous enables: clear, write, read and rewind. Words leave in the order they arrived, and no address is ever supplied by the user. Pointers advance on their own.

Four active-low status outputs report the fill level:

- a full indication;
- an empty indication;
- an over-half indication;
- a banded indication that is low while the buffer is nearly empty or nearly full.

A rewind strobe moves only the read side back to the first storage location. The data written since the last clear can then be replayed. An output-enable input decides whether a read word is presented as valid. It never stops a read from consuming its word.

Use the block where a producer and a consumer share one clock but run at different rates. It also suits a block of data that must be sent again after an error.

Top module: `fifo9_rt`

## Requirements
- R1: A clock edge with `clear_n` low empties the buffer and moves both pointers to location 0. After that edge, `full_n`=1, `empty_n`=0, `half_n`=1, `band_n`=0 and `dout_vld`=0.
- R2: A write (`wr_n` low) is accepted only while `full_n` is 1. When the stored word count reaches DEPTH, `full_n` goes to 0. Further writes leave the contents and the count unchanged.
- R3: A read (`rd_n` low) is accepted only while `empty_n` is 1. When the count is 0, `empty_n` is 0, and a read request neither moves the read side nor raises `dout_vld`.
- R4: Accepted reads return words in the order in which they were accepted for writing.
- R5: A read and a write that are both accepted on the same edge leave the count, and therefore every status flag, unchanged.
- R6: A clock edge with `rewind_n` low, and `clear_n` high, moves the read pointer to location 0 and leaves the write pointer alone. The count becomes the number of words written since the last clear, and later reads replay from the first such word. This holds while no more than DEPTH words have been written since the last clear.
- R7: On a clear edge or a rewind edge, `wr_n` and `rd_n` are ignored. No word is stored, no word is consumed, and `dout_vld` is 0 after that edge.
- R8: `band_n` is 0 when the count is below DEPTH/8 or above 7*DEPTH/8. It is 1 from DEPTH/8 to 7*DEPTH/8 inclusive. At DEPTH=1024 that means low at 0..127 and 897..1024.
- R9: `half_n` is 0 when the count is above DEPTH/2 (513 or more at DEPTH=1024). Otherwise it is 1.
- R10: After an edge that accepts a read while `oe_n` is low, `dout_vld` is 1 and `dout` carries the word read. After any other edge, `dout_vld` is 0.
- R11: A read accepted while `oe_n` is high gives `dout_vld`=0, but it still consumes its word. The next accepted read returns the word after it.
- R12: The status flags are registered. They take the values that belong to the new count on the same edge that changes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every strobe is sampled on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low |
| wr_n | input | 1 | Write request, active low |
| rd_n | input | 1 | Read request, active low |
| rewind_n | input | 1 | Read-side rewind to location 0, active low |
| oe_n | input | 1 | Output enable for read data, active low |
| din | input | 9 | Word to store |
| dout | output | 9 | Last word read (registered) |
| dout_vld | output | 1 | High when `dout` holds a word read with output enabled |
| full_n | output | 1 | Low when DEPTH words are stored |
| empty_n | output | 1 | Low when no word is stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| band_n | output | 1 | Low below DEPTH/8 or above 7*DEPTH/8 words |

## Verification
The bench fills the buffer through every flag threshold, one word at a time. A decode off by one, such as `>=` in place of `>`, therefore shows up at the exact count where the wrong edge sits: half-full would fall at 512 words, or the band flag would rise at 127. It writes into a full buffer and reads from an empty one, with and without the opposite strobe. A design that did not gate on the flags would wrap its pointers, or emit a valid word from nothing. Rewinds are applied with both request strobes held low, and are followed by full replays. A design that touched the write side, or honoured the strobes, would return a shifted or corrupt sequence. Reads with output disabled are followed by enabled reads, so a design that stalled the pointer when output was disabled would repeat the skipped words.

// File: rtl/fifo9_rt_pkg.sv
package fifo9_rt_pkg;

  // Registered status word, all active low.
  typedef struct packed {
    logic full_n;
    logic empty_n;
    logic half_n;
    logic band_n;
  } flag_t;

  localparam flag_t FLAGS_CLEAR = '{full_n: 1'b1, empty_n: 1'b0, half_n: 1'b1, band_n: 1'b0};

  // Map a word count onto the four status levels.
  function automatic flag_t decode_level(input int unsigned cnt, input int unsigned depth);
    flag_t f;
    int unsigned lo_edge;
    int unsigned hi_edge;
    lo_edge   = depth / 8;
    hi_edge   = depth - (depth / 8);
    f.full_n  = (cnt != depth);
    f.empty_n = (cnt != 0);
    f.half_n  = (cnt <= depth / 2);
    f.band_n  = (cnt >= lo_edge) && (cnt <= hi_edge);
    return f;
  endfunction

endpackage

// File: rtl/fifo9_rt_ptrs.sv
module fifo9_rt_ptrs #(
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          clear_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rewind_n,
  input  logic          full_n,
  input  logic          empty_n,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] cnt_next
);

  // Pointers carry one extra bit so the write side alone encodes 0..DEPTH.
  logic [CW-1:0] wptr_q;
  logic [CW-1:0] rptr_q;
  logic [CW-1:0] cnt_q;
  logic          run;

  assign run   = clear_n && rewind_n;
  assign wr_go = run && !wr_n && full_n;
  assign rd_go = run && !rd_n && empty_n;
  assign waddr = wptr_q[AW-1:0];
  assign raddr = rptr_q[AW-1:0];

  always_comb begin
    if (!clear_n) begin
      cnt_next = '0;
    end else if (!rewind_n) begin
      cnt_next = wptr_q;
    end else begin
      cnt_next = cnt_q + CW'(wr_go) - CW'(rd_go);
    end
  end

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (!rewind_n) begin
      rptr_q <= '0;
    end else begin
      if (wr_go) wptr_q <= wptr_q + 1'b1;
      if (rd_go) rptr_q <= rptr_q + 1'b1;
    end
    cnt_q <= cnt_next;
  end

endmodule

// File: rtl/fifo9_rt_flags.sv
module fifo9_rt_flags
  import fifo9_rt_pkg::*;
#(
  parameter  int DEPTH = 1024,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          clear_n,
  input  logic [CW-1:0] cnt_next,
  output flag_t         flags_q
);

  flag_t flags_d;

  always_comb begin
    flags_d = decode_level(int'(cnt_next), DEPTH);
  end

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      flags_q <= FLAGS_CLEAR;
    end else begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/fifo9_rt_store.sv
module fifo9_rt_store #(
  parameter  int DW    = 9,
  parameter  int DEPTH = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          clear_n,
  input  logic          oe_n,
  input  logic          wr_go,
  input  logic          rd_go,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] raddr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld
);

  logic [DW-1:0] ram [DEPTH];

  // Simple dual-port array: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (wr_go) ram[waddr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rd_go) dout <= ram[raddr];
  end

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= rd_go && !oe_n;
    end
  end

endmodule

// File: rtl/fifo9_rt.sv
module fifo9_rt
  import fifo9_rt_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 1024
) (
  input  logic          clk,
  input  logic          clear_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rewind_n,
  input  logic          oe_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_n,
  output logic          band_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          wr_go;
  logic          rd_go;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [CW-1:0] cnt_next;
  flag_t         flags_q;

  fifo9_rt_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .clear_n  (clear_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .rewind_n (rewind_n),
    .full_n   (flags_q.full_n),
    .empty_n  (flags_q.empty_n),
    .wr_go    (wr_go),
    .rd_go    (rd_go),
    .waddr    (waddr),
    .raddr    (raddr),
    .cnt_next (cnt_next)
  );

  fifo9_rt_flags #(.DEPTH(DEPTH)) u_flags (
    .clk      (clk),
    .clear_n  (clear_n),
    .cnt_next (cnt_next),
    .flags_q  (flags_q)
  );

  fifo9_rt_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .clear_n  (clear_n),
    .oe_n     (oe_n),
    .wr_go    (wr_go),
    .rd_go    (rd_go),
    .waddr    (waddr),
    .raddr    (raddr),
    .din      (din),
    .dout     (dout),
    .dout_vld (dout_vld)
  );

  assign full_n  = flags_q.full_n;
  assign empty_n = flags_q.empty_n;
  assign half_n  = flags_q.half_n;
  assign band_n  = flags_q.band_n;

endmodule

// File: rtl/fifo9_rt_chk.sv
module fifo9_rt_chk (
  input logic clk,
  input logic clear_n,
  input logic wr_n,
  input logic rd_n,
  input logic rewind_n,
  input logic oe_n,
  input logic dout_vld,
  input logic full_n,
  input logic empty_n,
  input logic half_n,
  input logic band_n
);

  AST_NO_VLD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!clear_n)
    (!empty_n) |=> !dout_vld); // R3

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!clear_n)
    (!empty_n && wr_n && rewind_n) |=> !empty_n); // R3

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!clear_n)
    (!full_n && rd_n && rewind_n) |=> !full_n); // R2

  AST_OE_BLOCKS_VLD: assert property (@(posedge clk) disable iff (!clear_n)
    oe_n |=> !dout_vld); // R11

  AST_REWIND_NO_VLD: assert property (@(posedge clk) disable iff (!clear_n)
    (!rewind_n) |=> !dout_vld); // R7

  AST_SIMUL_STABLE: assert property (@(posedge clk) disable iff (!clear_n)
    (full_n && empty_n && !wr_n && !rd_n && rewind_n)
      |=> ($stable(full_n) && $stable(empty_n) && $stable(half_n) && $stable(band_n))); // R5

  AST_FULL_LEVELS: assert property (@(posedge clk) disable iff (!clear_n)
    (!full_n) |-> (!half_n && !band_n && empty_n)); // R8

endmodule

bind fifo9_rt fifo9_rt_chk u_chk (
  .clk      (clk),
  .clear_n  (clear_n),
  .wr_n     (wr_n),
  .rd_n     (rd_n),
  .rewind_n (rewind_n),
  .oe_n     (oe_n),
  .dout_vld (dout_vld),
  .full_n   (full_n),
  .empty_n  (empty_n),
  .half_n   (half_n),
  .band_n   (band_n)
);

// File: tb/fifo9_rt_bench.sv
module fifo9_rt_bench;

  localparam int DW    = 9;
  localparam int DEPTH = 1024;

  logic          clk = 1'b0;
  logic          clear_n = 1'b0;
  logic          wr_n = 1'b1;
  logic          rd_n = 1'b1;
  logic          rewind_n = 1'b1;
  logic          oe_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_vld;
  logic          full_n;
  logic          empty_n;
  logic          half_n;
  logic          band_n;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference model state.
  logic [DW-1:0] ref_ram [DEPTH];
  int            wtot = 0;
  int            rtot = 0;
  logic [DW-1:0] exp_dout = '0;
  bit            exp_vld = 1'b0;
  int            gen = 0;

  fifo9_rt #(.DW(DW), .DEPTH(DEPTH)) u_fifo9_rt (
    .clk      (clk),
    .clear_n  (clear_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .rewind_n (rewind_n),
    .oe_n     (oe_n),
    .din      (din),
    .dout     (dout),
    .dout_vld (dout_vld),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .half_n   (half_n),
    .band_n   (band_n)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int k);
    return DW'((k * 37 + 5) % 512);
  endfunction

  // One clock: drive at the falling edge, update the model, compare after the next rise.
  task automatic step(input bit c, input bit w, input bit r, input bit rw, input bit o);
    int  cnt;
    bit  wacc;
    bit  racc;
    logic [DW-1:0] d;
    d = pattern(gen);
    clear_n = c; wr_n = w; rd_n = r; rewind_n = rw; oe_n = o; din = d;
    cnt = wtot - rtot;
    exp_vld = 1'b0;
    if (!c) begin
      wtot = 0; rtot = 0;
    end else if (!rw) begin
      rtot = 0;
    end else begin
      wacc = !w && (cnt < DEPTH);
      racc = !r && (cnt > 0);
      if (racc) begin
        exp_dout = ref_ram[rtot % DEPTH];
        exp_vld  = !o;
        rtot++;
      end
      if (wacc) begin
        ref_ram[wtot % DEPTH] = d;
        wtot++;
        gen++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cnt = wtot - rtot;
    check("R2 full_n",  int'(full_n),  int'(cnt != DEPTH));
    check("R3 empty_n", int'(empty_n), int'(cnt != 0));
    check("R9 half_n",  int'(half_n),  int'(cnt <= DEPTH / 2));
    check("R8 band_n",  int'(band_n),  int'(cnt >= DEPTH / 8 && cnt <= DEPTH - DEPTH / 8));
    check("R10 dout_vld", int'(dout_vld), int'(exp_vld));
    if (exp_vld) check("R4 dout", int'(dout), int'(exp_dout));
  endtask

  initial begin
    @(negedge clk);
    // R1: clear state
    step(0, 1, 1, 1, 0);
    step(0, 0, 0, 1, 0);
    check("R1 reset flags", {full_n, empty_n, half_n, band_n, dout_vld}, 5'b10100);
    // R3: reads on empty are ignored
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0);
    // Fill 200 words, crossing the lower band edge (R8, R12)
    for (int i = 0; i < 200; i++) step(1, 0, 1, 1, 0);
    step(1, 1, 0, 1, 0);
    step(1, 1, 0, 1, 0);
    // R6/R7: rewind with both strobes low; replay from word 0
    step(1, 0, 0, 0, 0);
    check("R6 count after rewind", wtot - rtot, 200);
    for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 0);
    // R11: reads with output disabled still consume
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 1);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0);
    // R5: simultaneous read and write
    for (int i = 0; i < 50; i++) step(1, 0, 0, 1, 0);
    // R2/R9/R8: fill to full, then extra writes
    while (wtot - rtot < DEPTH) step(1, 0, 1, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 1, 1, 0);
    check("R2 held at full", wtot - rtot, DEPTH);
    // Read and write at full: write is refused, read proceeds
    step(1, 0, 0, 1, 0);
    step(1, 0, 1, 1, 0);
    // Drain, then extra reads on empty (R3)
    while (wtot - rtot > 0) step(1, 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 0 == 1, 0, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 0);
    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      bit w;
      bit r;
      bit o;
      w = ($urandom % 100) < 55 ? 1'b0 : 1'b1;
      r = ($urandom % 100) < 50 ? 1'b0 : 1'b1;
      o = ($urandom % 4) == 0;
      step(1, w, r, 1, o);
    end
    // R1/R7: clear with write requested mid-stream
    step(0, 0, 0, 1, 0);
    check("R7 clear ignores write", {full_n, empty_n}, 2'b10);
    // R6: write 10, read 4, rewind, replay all 10
    for (int i = 0; i < 10; i++) step(1, 0, 1, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 1, 0);
    step(1, 1, 1, 0, 0);
    check("R6 rewind restores count", wtot - rtot, 10);
    for (int i = 0; i < 12; i++) step(1, 1, 0, 1, 0);
    // R6: writes after a rewind append behind the old data
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 0);
    step(1, 1, 1, 0, 0);
    for (int i = 0; i < 14; i++) step(1, 1, 0, 1, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule